// File: doc/BRIEF.md
# CAN transceiver operating mode controller

This block is the digital mode controller of a high-speed CAN transceiver. It selects one of five operating modes (Normal, Listen-only, Standby, Go-to-Sleep and Sleep) from two host control pins and from internal flags. The host control pins are an active-low standby input and an enable input. The internal flags are a wake request, a core-supply (VCC/VIO) undervoltage flag and a battery undervoltage flag. The supply flags arrive already debounced.

From the selected mode the block drives the enables for the analog sections:
- the transmitter;
- the receiver path (high-speed or low-power);
- the bus bias level (mid-supply or ground);
- the split common-mode output;
- the inhibit output that keeps external regulators powered.

Sleep is reached only through a timed Go-to-Sleep state, unless the core-supply undervoltage flag forces it. The hold time is counted in pulses of an external timer tick. The control pins pass through a two-flop synchronizer. The flags are used directly.

Top module: `can_mode_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the mode is Standby. In that state the inhibit output is 1 and the transmitter, high-speed receiver, mid bias and split outputs are 0. The `mode_o` encoding is Normal=0, Listen-only=1, Standby=2, Go-to-Sleep=3, Sleep=4.
- R2: With standby pin HIGH and enable HIGH, the mode becomes Normal. In Normal, the transmitter, high-speed receiver, mid bias, split and inhibit outputs are all 1.
- R3: With standby pin HIGH and enable LOW, the mode becomes Listen-only. In Listen-only the transmitter is 0, while the high-speed receiver, mid bias, split and inhibit outputs are 1.
- R4: From Normal, Listen-only or Standby, standby pin LOW with enable HIGH and wake clear selects Go-to-Sleep. Standby pin LOW with either enable LOW or wake set selects Standby.
- R5: Go-to-Sleep drives the outputs exactly as Standby does. It moves to Sleep only once HOLD_TICKS tick pulses have been counted inside it. After HOLD_TICKS-1 pulses it is still in Go-to-Sleep.
- R6: Go-to-Sleep is abandoned if either control pin changes or wake sets before the hold completes. The mode then follows the pin rule of R4 or R2/R3. A later re-entry starts the hold count from zero.
- R7: From Sleep:
  - standby pin HIGH goes to Normal or to Listen-only, according to enable;
  - standby pin LOW with wake set goes to Standby;
  - standby pin LOW with wake clear stays in Sleep, whatever the enable level.
- R8: The core-supply undervoltage flag forces Sleep within one clock, regardless of the pins and the other flags. The inhibit output is 0 in Sleep and only in Sleep.
- R9: The battery undervoltage flag, with the core flag clear, forces Standby within one clock. Once it clears, the mode follows the pin levels again.
- R10: Control pin changes take effect only after the two-flop synchronizer. Tick pulses outside Go-to-Sleep do not shorten a later hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_n_i | input | 1 | Standby control pin, active low (asynchronous) |
| en_i | input | 1 | Enable control pin (asynchronous) |
| wake_i | input | 1 | Wake request flag |
| uv_core_i | input | 1 | Core supply undervoltage flag |
| uv_batt_i | input | 1 | Battery undervoltage flag |
| tick_i | input | 1 | One-cycle timer tick for the sleep hold |
| mode_o | output | 3 | Current mode (encoding in R1) |
| tx_en_o | output | 1 | Transmitter enable |
| rx_hs_o | output | 1 | 1 selects the high-speed receiver, 0 the low-power one |
| bias_mid_o | output | 1 | 1 biases the bus at mid-supply, 0 at ground |
| split_en_o | output | 1 | Split output drive enable |
| inh_en_o | output | 1 | Inhibit output active (0 = floating) |

## Verification
The bench targets the hold boundary. It checks Go-to-Sleep after HOLD_TICKS-1 pulses and Sleep after one more, so an off-by-one counter falls asleep early or late. Aborts by a pin change and by wake are tested, and a re-entry must run a full fresh hold. A counter that was not cleared on abort would sleep too soon. Priority is probed with both supply flags set at once, where a swapped order shows Standby instead of Sleep. It is also probed with Sleep held by a low standby pin while enable rises, where a design that reused the Standby rule would drift into Go-to-Sleep. Random pin and flag sequences, with the tick held low, compare every mode and every output against a bench model.

// File: rtl/canmc_pkg.sv
package canmc_pkg;

  typedef enum logic [2:0] {
    M_NORMAL  = 3'd0,
    M_LISTEN  = 3'd1,
    M_STANDBY = 3'd2,
    M_GOSLEEP = 3'd3,
    M_SLEEP   = 3'd4
  } mode_e;

  // Mode chosen by the pins from any awake state.
  function automatic mode_e pin_rule(input logic stby_n, input logic en,
                                     input logic wake);
    if (stby_n)          return en ? M_NORMAL : M_LISTEN;
    else if (en && !wake) return M_GOSLEEP;
    else                 return M_STANDBY;
  endfunction

endpackage

// File: rtl/canmc_sync.sv
module canmc_sync #(
  parameter int W = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_i;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/canmc_hold_timer.sv
module canmc_hold_timer #(
  parameter int HOLD_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_gosleep,
  input  logic stby_n,
  input  logic en,
  input  logic tick,
  output logic hold_done
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_TICKS);

  logic [1:0]    pins_lat;
  logic          lat_en;
  logic          pins_moved;
  logic [CW-1:0] cnt_q, cnt_d;

  // Pins are captured every cycle outside Go-to-Sleep, frozen inside it.
  assign lat_en     = !in_gosleep;
  assign pins_moved = (pins_lat != {stby_n, en});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pins_lat <= 2'b00;
    else if (lat_en) pins_lat <= {stby_n, en};
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!in_gosleep || pins_moved) cnt_d = '0;
    else if (tick && cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hold_done = (cnt_q == LIMIT);

  a_r5_cnt_bound : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  a_r6_cnt_clear : assert property (@(posedge clk) disable iff (!rst_n)
    !in_gosleep |=> cnt_q == '0);
endmodule

// File: rtl/canmc_fsm.sv
module canmc_fsm
  import canmc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stby_n,
  input  logic  en,
  input  logic  wake,
  input  logic  uv_core,
  input  logic  uv_batt,
  input  logic  hold_done,
  output mode_e state_o
);
  mode_e state_q, state_d, rule;

  assign rule = pin_rule(stby_n, en, wake);

  always_comb begin
    state_d = state_q;
    if (uv_core) begin
      state_d = M_SLEEP;
    end else if (uv_batt) begin
      state_d = M_STANDBY;
    end else begin
      unique case (state_q)
        M_NORMAL, M_LISTEN, M_STANDBY: state_d = rule;
        M_GOSLEEP: begin
          if (rule != M_GOSLEEP) state_d = rule;
          else if (hold_done)    state_d = M_SLEEP;
          else                   state_d = M_GOSLEEP;
        end
        M_SLEEP: begin
          if (stby_n)    state_d = en ? M_NORMAL : M_LISTEN;
          else if (wake) state_d = M_STANDBY;
          else           state_d = M_SLEEP;
        end
        default: state_d = M_STANDBY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= M_STANDBY;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  a_r8_uv_core_sleep : assert property (@(posedge clk) disable iff (!rst_n)
    uv_core |=> state_q == M_SLEEP);
  a_r9_uv_batt_standby : assert property (@(posedge clk) disable iff (!rst_n)
    (uv_batt && !uv_core) |=> state_q == M_STANDBY);
  a_r5_sleep_entry : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == M_GOSLEEP && !uv_core && !hold_done) |=> state_q != M_SLEEP);
  a_r7_sleep_keeps : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == M_SLEEP && !stby_n && !wake && !uv_batt) |=> state_q == M_SLEEP);
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import canmc_pkg::*;
#(
  parameter int HOLD_TICKS = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_n_i,
  input  logic       en_i,
  input  logic       wake_i,
  input  logic       uv_core_i,
  input  logic       uv_batt_i,
  input  logic       tick_i,
  output logic [2:0] mode_o,
  output logic       tx_en_o,
  output logic       rx_hs_o,
  output logic       bias_mid_o,
  output logic       split_en_o,
  output logic       inh_en_o
);
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  logic [1:0] pins_s;
  logic       hold_done;
  mode_e      state;

  // Reset: asserted asynchronously, released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  canmc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i({stby_n_i, en_i}), .q_o(pins_s)
  );

  canmc_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .in_gosleep(state == M_GOSLEEP),
    .stby_n(pins_s[1]), .en(pins_s[0]), .tick(tick_i), .hold_done(hold_done)
  );

  canmc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_s), .stby_n(pins_s[1]), .en(pins_s[0]),
    .wake(wake_i), .uv_core(uv_core_i), .uv_batt(uv_batt_i),
    .hold_done(hold_done), .state_o(state)
  );

  always_comb begin
    tx_en_o    = 1'b0;
    rx_hs_o    = 1'b0;
    bias_mid_o = 1'b0;
    split_en_o = 1'b0;
    inh_en_o   = 1'b1;
    unique case (state)
      M_NORMAL: begin
        tx_en_o = 1'b1; rx_hs_o = 1'b1; bias_mid_o = 1'b1; split_en_o = 1'b1;
      end
      M_LISTEN: begin
        rx_hs_o = 1'b1; bias_mid_o = 1'b1; split_en_o = 1'b1;
      end
      M_SLEEP: inh_en_o = 1'b0;
      default: ;
    endcase
  end

  assign mode_o = state;

  a_r2_tx_needs_rx : assert property (@(posedge clk) disable iff (!rst_n_s)
    tx_en_o |-> (rx_hs_o && split_en_o && inh_en_o));
endmodule

// File: tb/tb_can_mode_ctrl.sv
`timescale 1ns/1ps
module tb_can_mode_ctrl;
  localparam int HOLD = 16;
  localparam int NORMAL = 0, LISTEN = 1, STANDBY = 2, GOSLEEP = 3, SLEEP = 4;

  logic clk = 1'b0;
  logic rst_n, stby_n, en, wake, uvc, uvb, tick;
  logic [2:0] mode;
  logic tx_en, rx_hs, bias_mid, split_en, inh_en;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_mode_ctrl #(.HOLD_TICKS(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .stby_n_i(stby_n), .en_i(en), .wake_i(wake),
    .uv_core_i(uvc), .uv_batt_i(uvb), .tick_i(tick), .mode_o(mode),
    .tx_en_o(tx_en), .rx_hs_o(rx_hs), .bias_mid_o(bias_mid),
    .split_en_o(split_en), .inh_en_o(inh_en)
  );

  function automatic int rule(bit s, bit e, bit w);
    if (s) return e ? NORMAL : LISTEN;
    if (e && !w) return GOSLEEP;
    return STANDBY;
  endfunction

  // Bench model with the tick held low.
  function automatic int step(int m, bit s, bit e, bit w, bit c, bit b);
    if (c) return SLEEP;
    if (b) return STANDBY;
    if (m == SLEEP) begin
      if (s) return e ? NORMAL : LISTEN;
      return w ? STANDBY : SLEEP;
    end
    return rule(s, e, w);
  endfunction

  function automatic int settle(int m, bit s, bit e, bit w, bit c, bit b);
    int r = m;
    for (int i = 0; i < 3; i++) r = step(r, s, e, w, c, b);
    return r;
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_mode(string tag, int exp);
    int outs, eo;
    outs = {tx_en, rx_hs, bias_mid, split_en, inh_en};
    eo = {exp == NORMAL, exp <= LISTEN, exp <= LISTEN, exp <= LISTEN, exp != SLEEP};
    chk({tag, " mode"}, mode, exp);
    chk({tag, " outputs"}, outs, eo);
  endtask

  task automatic waitn(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic set_pins(bit s, bit e);
    @(negedge clk); stby_n = s; en = e;
    waitn(5);
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int exp;
    rst_n = 1'b0; stby_n = 1'b1; en = 1'b1; wake = 1'b0;
    uvc = 1'b0; uvb = 1'b0; tick = 1'b0;
    waitn(4);
    chk_mode("R1 in reset", STANDBY);
    rst_n = 1'b1;
    waitn(1);
    chk_mode("R1 after release", STANDBY);
    waitn(6);
    chk_mode("R2 normal", NORMAL);
    set_pins(1'b1, 1'b0);
    chk_mode("R3 listen", LISTEN);
    set_pins(1'b0, 1'b0);
    chk_mode("R4 standby en low", STANDBY);

    // R10: ticks outside Go-to-Sleep do not count
    pulse_ticks(HOLD);
    set_pins(1'b0, 1'b1);
    chk_mode("R4 go-to-sleep", GOSLEEP);
    pulse_ticks(HOLD - 1);
    chk_mode("R5/R10 hold not yet", GOSLEEP);
    pulse_ticks(1);
    waitn(1);
    chk_mode("R5 sleep after hold", SLEEP);
    chk("R8 inh floats in sleep", inh_en, 0);

    // R7: enable toggling with stby low keeps Sleep
    set_pins(1'b0, 1'b0);
    set_pins(1'b0, 1'b1);
    chk_mode("R7 stay asleep", SLEEP);
    set_pins(1'b1, 1'b0);
    chk_mode("R7 sleep to listen", LISTEN);

    // R6 abort by pin change, then fresh count
    set_pins(1'b0, 1'b1);
    pulse_ticks(HOLD - 1);
    chk_mode("R6 pre-abort", GOSLEEP);
    set_pins(1'b0, 1'b0);
    chk_mode("R6 abort pin", STANDBY);
    set_pins(1'b0, 1'b1);
    pulse_ticks(HOLD - 1);
    chk_mode("R6 restart count", GOSLEEP);

    // R6 abort by wake
    @(negedge clk) wake = 1'b1;
    waitn(2);
    chk_mode("R6 abort wake", STANDBY);
    waitn(3);
    chk_mode("R4 wake keeps standby", STANDBY);
    @(negedge clk) wake = 1'b0;
    waitn(3);
    pulse_ticks(HOLD);
    waitn(1);
    chk_mode("R5 sleep after fresh hold", SLEEP);
    set_pins(1'b0, 1'b1);
    @(negedge clk) wake = 1'b1;
    waitn(2);
    chk_mode("R7 sleep wake standby", STANDBY);
    @(negedge clk) wake = 1'b0;

    // R8/R9 supply flags
    set_pins(1'b1, 1'b1);
    chk_mode("R2 normal again", NORMAL);
    @(negedge clk) uvb = 1'b1;
    @(negedge clk);
    chk_mode("R9 batt standby", STANDBY);
    @(negedge clk) uvc = 1'b1;
    @(negedge clk);
    chk_mode("R8 core over batt", SLEEP);
    @(negedge clk) uvc = 1'b0; uvb = 1'b0;
    waitn(2);
    chk_mode("R9 release follows pins", NORMAL);
    @(negedge clk) uvc = 1'b1;
    @(negedge clk);
    chk_mode("R8 core from normal", SLEEP);
    @(negedge clk) uvc = 1'b0;
    waitn(2);
    chk_mode("R7 release stby high", NORMAL);

    // Random phase, tick held low
    void'($urandom(32'd4242));
    exp = NORMAL;
    for (int it = 0; it < 300; it++) begin
      bit ns, ne, nw, nc, nb;
      ns = $urandom_range(1, 0); ne = $urandom_range(1, 0);
      nw = ($urandom_range(2, 0) == 0);
      nc = ($urandom_range(7, 0) == 0);
      nb = ($urandom_range(7, 0) == 0);
      @(negedge clk) stby_n = ns; en = ne;
      waitn(4);
      exp = settle(exp, ns, ne, wake, uvc, uvb);
      @(negedge clk) wake = nw; uvc = nc; uvb = nb;
      waitn(3);
      exp = settle(exp, ns, ne, nw, nc, nb);
      chk_mode("R4/R7/R8/R9 random", exp);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule